// File: doc/BRIEF.md
# Bus Transceiver Mode and Wake-Up Controller

This block holds the digital control of a two-mode differential bus transceiver. One select input chooses the mode. In active mode a low transmit request enables the bus driver, and the receive output follows the bus comparator: low while the bus is dominant, high while it is recessive. In sleep mode the driver and the normal receiver are turned off. A low-power activity input is then watched instead.

In sleep mode a dominant level must persist past a programmable filter time before it counts as a wake event. Shorter pulses leave no trace, and any recessive sample restarts the filter. Once a wake event is accepted, the receive output goes low after a programmable assert delay. The indication is not latched. When the bus returns to recessive, the output goes high again after a programmable release delay. If the bus turns dominant again during that release window, the indication stays low.

The asynchronous select, transmit and comparator inputs pass through synchronisers. All three outputs are registered, so an input level reaches the outputs three clock edges after it is applied.

Top module: `bustrx_ctrl`

## Requirements
- R1: With `stb_i` high the block is in sleep mode and `rx_en_o` is 0; with `stb_i` low it is in active mode and `rx_en_o` is 1. A level applied before clock edge n shows at the outputs after edge n+2 (default two synchroniser stages plus one output register).
- R2: In active mode `rxd_o` is the inverse of `bus_dom_i` (1 = dominant), with the R1 latency.
- R3: In active mode `drv_en_o` is 1 exactly when `txd_i` is 0, with the R1 latency.
- R4: In sleep mode `drv_en_o` is 0 whatever `txd_i` is, and `rxd_o` is 1 while no wake event is pending.
- R5: In sleep mode a wake event is accepted only after FILT_CYC+1 consecutive dominant samples. A dominant run of FILT_CYC samples or fewer has no effect on `rxd_o`, and a single recessive sample restarts the count.
- R6: If `bus_dom_i` is first applied dominant before edge 0 and stays dominant for at least FILT_CYC+1 edges, `rxd_o` is low from edge FILT_CYC+ASSERT_DLY+3. This holds even if the bus is released during the assert delay.
- R7: The wake indication is not latched. If the dominant run covers edges 0..L-1, `rxd_o` returns to 1 at edge max(L+2, FILT_CYC+ASSERT_DLY+3)+REL_DLY+1.
- R8: A dominant sample that arrives while the release delay is running cancels the release, and `rxd_o` stays low without a high gap.
- R9: Leaving sleep mode clears all wake state. On re-entry to sleep mode with the bus recessive, `rxd_o` is 1 from the first cycle.
- R10: While `rst_n` (synchronous, active low) is 0, the next edge gives `drv_en_o`=0, `rx_en_o`=0 and `rxd_o`=1. The synchronisers reset to sleep mode, recessive transmit and recessive bus, so the block stays in sleep mode until the select input has been sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stb_i | input | 1 | Mode select, asynchronous: 1 = sleep, 0 = active |
| txd_i | input | 1 | Transmit request, asynchronous: 0 = dominant |
| bus_dom_i | input | 1 | Bus comparator, asynchronous: 1 = bus dominant |
| drv_en_o | output | 1 | Bus driver enable |
| rx_en_o | output | 1 | Normal receiver enable |
| rxd_o | output | 1 | Receive data in active mode, wake indication (low) in sleep mode |

## Verification
The bench builds the block with FILT_CYC=3, ASSERT_DLY=2, REL_DLY=3 and two synchroniser stages. With these values every dominant pulse length from 1 up to FILT_CYC+ASSERT_DLY+6 can be swept cycle by cycle. The sweep covers the filter threshold and pulses that end inside the assert delay. It also covers a broken pulse that restarts the filter, and a dominant return inside the short release window. Active mode is swept over every transmit and bus combination, and the mode-change clearing is checked at the receive output.

// File: rtl/bustrx_pkg.sv
package bustrx_pkg;

   // wake detector states (sleep mode only)
   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_PEND   = 2'd1,
      WK_ACTIVE = 2'd2,
      WK_REL    = 2'd3
   } wake_st_t;

   // synchronised pin bundle
   typedef struct packed {
      logic stb;
      logic txd;
      logic dom;
   } pin_vec_t;

   // reset: sleep mode, recessive transmit, recessive bus
   localparam pin_vec_t PIN_RST = '{stb: 1'b1, txd: 1'b1, dom: 1'b0};

endpackage

// File: rtl/bustrx_sync.sv
module bustrx_sync #(
   parameter int              W       = 3,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/bustrx_wake_filt.sv
module bustrx_wake_filt
   import bustrx_pkg::*;
#(
   parameter int FILT_CYC   = 40,
   parameter int ASSERT_DLY = 16,
   parameter int REL_DLY    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,      // sleep mode
   input  logic dom,     // synchronised bus dominant
   output logic wake_o   // wake indication active
);

   localparam int DMAX = (ASSERT_DLY > REL_DLY) ? ASSERT_DLY : REL_DLY;
   localparam int FW   = $clog2(FILT_CYC + 1);
   localparam int DW   = (DMAX < 2) ? 1 : $clog2(DMAX + 1);
   localparam logic [FW-1:0] F_LIM = FW'(FILT_CYC);
   localparam logic [DW-1:0] A_LIM = DW'(ASSERT_DLY - 1);
   localparam logic [DW-1:0] R_LIM = DW'(REL_DLY - 1);

   wake_st_t      st_q;
   logic [FW-1:0] fcnt_q;
   logic [DW-1:0] dcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         st_q   <= WK_IDLE;
         fcnt_q <= '0;
         dcnt_q <= '0;
      end else begin
         unique case (st_q)
            WK_IDLE: begin
               if (!dom) begin
                  fcnt_q <= '0;
               end else if (fcnt_q == F_LIM) begin
                  st_q   <= WK_PEND;
                  fcnt_q <= '0;
                  dcnt_q <= '0;
               end else begin
                  fcnt_q <= fcnt_q + 1'b1;
               end
            end
            WK_PEND: begin
               if (dcnt_q == A_LIM) begin
                  st_q   <= WK_ACTIVE;
                  dcnt_q <= '0;
               end else begin
                  dcnt_q <= dcnt_q + 1'b1;
               end
            end
            WK_ACTIVE: begin
               if (!dom) begin
                  st_q   <= WK_REL;
                  dcnt_q <= '0;
               end
            end
            WK_REL: begin
               if (dom) begin
                  st_q   <= WK_ACTIVE;
                  dcnt_q <= '0;
               end else if (dcnt_q == R_LIM) begin
                  st_q   <= WK_IDLE;
                  dcnt_q <= '0;
               end else begin
                  dcnt_q <= dcnt_q + 1'b1;
               end
            end
            default: st_q <= WK_IDLE;
         endcase
      end
   end

   assign wake_o = (st_q == WK_ACTIVE) || (st_q == WK_REL);

endmodule

// File: rtl/bustrx_ctrl.sv
module bustrx_ctrl
   import bustrx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 40,
   parameter int ASSERT_DLY  = 16,
   parameter int REL_DLY     = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_i,
   input  logic txd_i,
   input  logic bus_dom_i,
   output logic drv_en_o,
   output logic rx_en_o,
   output logic rxd_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_CYC < 1 || ASSERT_DLY < 1 || REL_DLY < 1) begin : g_bad_tim
      $error("FILT_CYC, ASSERT_DLY and REL_DLY must be at least 1");
   end

   pin_vec_t pin_raw, pin_s;
   logic     stb_s, txd_s, dom_s;
   logic     wake;

   assign pin_raw = '{stb: stb_i, txd: txd_i, dom: bus_dom_i};

   bustrx_sync #(
      .W       ($bits(pin_vec_t)),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (pin_s)
   );

   assign stb_s = pin_s.stb;
   assign txd_s = pin_s.txd;
   assign dom_s = pin_s.dom;

   bustrx_wake_filt #(
      .FILT_CYC   (FILT_CYC),
      .ASSERT_DLY (ASSERT_DLY),
      .REL_DLY    (REL_DLY)
   ) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (stb_s),
      .dom    (dom_s),
      .wake_o (wake)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drv_en_o <= 1'b0;
         rx_en_o  <= 1'b0;
         rxd_o    <= 1'b1;
      end else begin
         drv_en_o <= !stb_s && !txd_s;
         rx_en_o  <= !stb_s;
         rxd_o    <= stb_s ? !wake : !dom_s;
      end
   end

endmodule

// File: rtl/bustrx_ctrl_chk.sv
module bustrx_ctrl_chk #(
   parameter int FILT_CYC   = 40,
   parameter int ASSERT_DLY = 16,
   parameter int REL_DLY    = 16
) (
   input logic clk,
   input logic rst_n,
   input logic stb_s,
   input logic dom_s,
   input logic drv_en_o,
   input logic rx_en_o,
   input logic rxd_o
);

   localparam int RUN_LIM = REL_DLY + ASSERT_DLY + 2;

   // consecutive recessive samples seen in sleep mode (saturating)
   logic [15:0] rec_run;
   always_ff @(posedge clk) begin
      if (!rst_n || !stb_s || dom_s) rec_run <= '0;
      else if (rec_run != 16'hFFFF) rec_run <= rec_run + 1'b1;
   end

   p_rx_en_sleep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      stb_s |=> !rx_en_o);
   p_rx_en_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_s |=> rx_en_o);
   p_rxd_follows_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_s |=> (rxd_o == !$past(dom_s)));
   p_drv_off_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stb_s |=> !drv_en_o);
   p_not_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_s && (int'(rec_run) > RUN_LIM)) |-> rxd_o);
   p_sleep_entry_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stb_s) |=> rxd_o);
   p_reset_state_r10: assert property (@(posedge clk)
      !rst_n |=> (!drv_en_o && !rx_en_o && rxd_o));

endmodule

bind bustrx_ctrl bustrx_ctrl_chk #(
   .FILT_CYC   (FILT_CYC),
   .ASSERT_DLY (ASSERT_DLY),
   .REL_DLY    (REL_DLY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .stb_s    (stb_s),
   .dom_s    (dom_s),
   .drv_en_o (drv_en_o),
   .rx_en_o  (rx_en_o),
   .rxd_o    (rxd_o)
);

// File: tb/bustrx_ctrl_test.sv
`timescale 1ns/1ps
module bustrx_ctrl_test;

   localparam int F = 3;
   localparam int A = 2;
   localparam int R = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stb = 1'b1, txd = 1'b1, dom = 1'b0;
   logic drv_en, rx_en, rxd;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   bustrx_ctrl #(
      .SYNC_STAGES (2),
      .FILT_CYC    (F),
      .ASSERT_DLY  (A),
      .REL_DLY     (R)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb_i     (stb),
      .txd_i     (txd),
      .bus_dom_i (dom),
      .drv_en_o  (drv_en),
      .rx_en_o   (rx_en),
      .rxd_o     (rxd)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // Drives a dominant run of l1, a recessive gap, a second run of l2,
   // and expects rxd low exactly on negedges lo_first..lo_last.
   task automatic run_pulse(input int l1, input int gap, input int l2,
                            input int lo_first, input int lo_last, input string req);
      int nbad = 0;
      int bad_i = -1;
      int bad_v = 0;
      int n = l1 + gap + l2 + F + A + R + 12;
      for (int i = 0; i <= n; i++) begin
         @(negedge clk);
         begin
            int expv = (i >= lo_first && i <= lo_last) ? 0 : 1;
            if (int'(rxd) != expv) begin
               if (nbad == 0) begin bad_i = i; bad_v = int'(rxd); end
               nbad++;
            end
         end
         dom = (i < l1) || (i >= l1 + gap && i < l1 + gap + l2);
      end
      if (nbad != 0)
         $display("  %s: first mismatch at cycle %0d", req, bad_i);
      chk(nbad == 0, req, bad_v, (bad_i >= lo_first && bad_i <= lo_last) ? 0 : 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R10: reset state with active-mode stimulus on the pins
      stb = 1'b0; txd = 1'b0; dom = 1'b1;
      wait_neg(5);
      chk(!drv_en && !rx_en && rxd, "R10 reset outputs",
          {drv_en, rx_en, rxd}, 3'b001);
      rst_n = 1'b1;                     // before edge 0
      wait_neg(2);                      // edge 1 done
      chk(!rx_en, "R10 sleep until select sampled", rx_en, 0);
      wait_neg(1);                      // edge 2 done
      chk(rx_en && drv_en && !rxd, "R1 active after latency",
          {rx_en, drv_en, rxd}, 3'b110);

      // R2 R3: every transmit/bus combination in active mode
      for (int c = 0; c < 4; c++) begin
         txd = c[0]; dom = c[1];
         wait_neg(3);
         chk(drv_en == !c[0], "R3 driver follows transmit", drv_en, !c[0]);
         chk(rxd == !c[1], "R2 receive follows bus", rxd, !c[1]);
      end

      // R1 R4: sleep mode disables driver and receiver
      dom = 1'b0;
      for (int t = 0; t < 2; t++) begin
         stb = 1'b1; txd = t[0];
         wait_neg(3);
         chk(!drv_en && !rx_en && rxd, "R4 sleep outputs",
             {drv_en, rx_en, rxd}, 3'b001);
      end
      txd = 1'b1;
      wait_neg(4);

      // R5 R6 R7: sweep the dominant run length
      for (int l = 1; l <= F + A + 6; l++) begin
         int x;
         x = (l + 2 > F + A + 3) ? l + 2 : F + A + 3;
         if (l >= F + 1)
            run_pulse(l, 0, 0, F + A + 4, x + R + 1, "R6 R7 wake window");
         else
            run_pulse(l, 0, 0, 1, 0, "R5 short pulse ignored");
      end

      // R5: a single recessive sample restarts the filter
      run_pulse(F, 1, F, 1, 0, "R5 filter restart");

      // R8: dominant return inside the release delay keeps rxd low
      run_pulse(F + A + 2, 1, 4, F + A + 4, (F + A + 2) + 1 + 4 + R + 3, "R8 release cancelled");

      // R9: leaving sleep clears a live wake indication
      dom = 1'b1;
      wait_neg(20);
      chk(!rxd, "R6 wake held low", rxd, 0);
      stb = 1'b0; dom = 1'b0;
      wait_neg(6);
      chk(rxd && rx_en, "R9 active mode recessive", {rxd, rx_en}, 2'b11);
      stb = 1'b1;
      begin
         int lows = 0;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!rxd) lows++;
         end
         chk(lows == 0, "R9 no stale wake on re-entry", lows, 0);
      end
      chk(!rx_en && !drv_en, "R4 sleep after re-entry", {rx_en, drv_en}, 2'b00);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule